// File: doc/BRIEF.md
# Time-Slotted Petri Net Engine

This block steps a fixed, marked Petri net through successive markings in hardware. The places, the transitions and the arcs between them are fixed when the block is elaborated. Two bit matrices give the input arcs and the output arcs, and a packed vector gives the starting marking. Every arc has weight one. Time is divided into major cycles of NT+1 clock cycles. The first slot of a major cycle commits the tokens produced during the previous major cycle. Each of the NT remaining slots belongs to exactly one transition. In its slot, that transition checks its input places and fires if it can.

A firing takes one token from each input place at once, so a transition in a later slot sees the reduced counts. The tokens that a firing produces are only collected in a per-place pending counter. They are added to the place at the next commit slot, so they can first enable a transition in the following major cycle. A mode input selects the order in which transitions get their slots. In fixed order, transition j always gets slot j+1. In shuffled order, the order is a new permutation, drawn from a free-running LFSR, in every major cycle. The engine never halts. When nothing is enabled, major cycles continue and the marking stays unchanged. Place counters saturate at their maximum value, and a sticky flag records that saturation occurred.

Top module: `pn_engine`

## Requirements
- R1: While rst_n is low, marking equals INIT, fire is all zero, and boundary and overflow are low. After rst_n is released, the first clock edge is a commit slot.
- R2: boundary is high for one cycle in every major cycle, and consecutive pulses are exactly NT+1 cycles apart. The pulses continue whether or not any transition is enabled.
- R3: At most one fire bit is high in any cycle. Each transition fires at most once per major cycle, and each strobe lasts one cycle.
- R4: When mode was 0 (fixed order) at the commit edge, transition j is evaluated in slot j+1. Its strobe, if it fires, is seen in the (j+1)-th cycle after the boundary cycle.
- R5: A transition fires in its slot exactly when every input place holds at least one committed token. A transition with no input places always fires in its slot.
- R6: A firing lowers each of its input places by one in the same cycle in which its fire bit is seen.
- R7: Tokens produced by a firing are not added to any place until the commit slot. Place counts never rise outside a boundary cycle, and pending tokens cannot enable a transition in the major cycle that produced them.
- R8: At commit, a place whose count plus pending tokens exceeds 2^CW-1 is set to 2^CW-1. overflow then rises in the boundary cycle and stays high until reset.
- R9: When mode was 1 (shuffled) at the commit edge, every transition still gets exactly one slot in that major cycle. The slot position of a given transition varies between major cycles.
- R10: The arc bit for transition t and place p is at bit t*NP+p of IN_MAT and OUT_MAT. Place p occupies marking[p*CW +: CW], with the same layout in INIT. mode is sampled only at the commit edge and applies to the whole following major cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, release synchronous to clk |
| mode | input | 1 | Slot order: 0 fixed, 1 shuffled; sampled at the commit edge |
| marking | output | NP*CW | Current committed-minus-consumed token count of every place |
| fire | output | NT | One-cycle strobe per transition when it fires |
| boundary | output | 1 | High in the cycle after each commit |
| overflow | output | 1 | Sticky flag, set when any place saturated at commit |

## Verification
The net used has a fork, a join, two transitions competing for one place, and a source transition with no inputs that eventually saturates a place. Long runs in fixed order are compared strobe by strobe and count by count against a reference model of the net. These runs separate correct slot ownership, immediate consumption and deferred production from variants that commit early or evaluate in the wrong order. Shuffled runs are checked for legality: only one strobe per transition, only enabled transitions firing, and the source always receiving a slot. The source's slot position must also vary, which shows that the order actually changes. A mid-run reset and random switching between modes at major-cycle boundaries check that the mode applies to whole major cycles and that the initial marking is restored.

// File: rtl/pn_pkg.sv
package pn_pkg;

  typedef enum logic {
    PN_FIXED    = 1'b0,
    PN_SHUFFLED = 1'b1
  } pn_order_e;

  // Width needed to hold values 0..n-1, at least one bit.
  function automatic int pn_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pn_slot_seq.sv
// Minor-slot sequencer: slot 0 commits, slots 1..NT each select one transition.
module pn_slot_seq
  import pn_pkg::*;
#(
  parameter int NT = 5,
  parameter int TW = pn_bits(NT),
  parameter int LW = 16,
  parameter logic [LW-1:0] SEED = 16'hACE1,
  parameter logic [LW-1:0] TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pn_order_e     order_i,
  output logic          commit_o,
  output logic          active_o,
  output logic [TW-1:0] tsel_o
);

  localparam int SW = pn_bits(NT + 1);
  localparam logic [SW-1:0] LAST = SW'(NT);
  localparam logic [TW-1:0] TOP = TW'(NT - 1);
  localparam logic [TW:0] NTX = (TW + 1)'(NT);

  logic [SW-1:0] slot_q, slot_n;
  logic [LW-1:0] lfsr_q, lfsr_n;
  pn_order_e     ord_q, ord_n;
  logic [TW-1:0] off_q, off_n;
  logic          rev_q, rev_n;
  logic          at_commit;

  logic [TW-1:0] k, kr;
  logic [TW:0]   sum, wrapped;

  assign at_commit = (slot_q == '0);

  // next state
  always_comb begin
    slot_n = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    lfsr_n = {1'b0, lfsr_q[LW-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
    ord_n  = order_i;
    off_n  = TW'(lfsr_q % LW'(NT));
    rev_n  = lfsr_q[LW-1];
  end

  // slot-to-transition mapping for the current major cycle
  always_comb begin
    k       = TW'(slot_q - 1'b1);
    kr      = rev_q ? (TOP - k) : k;
    sum     = {1'b0, kr} + {1'b0, off_q};
    wrapped = (sum >= NTX) ? (sum - NTX) : sum;
    tsel_o  = (ord_q == PN_FIXED) ? k : wrapped[TW-1:0];
  end

  assign commit_o = at_commit;
  assign active_o = !at_commit;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      lfsr_q <= SEED;
    end else begin
      slot_q <= slot_n;
      lfsr_q <= lfsr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q <= PN_FIXED;
      off_q <= '0;
      rev_q <= 1'b0;
    end else if (at_commit) begin
      ord_q <= ord_n;
      off_q <= off_n;
      rev_q <= rev_n;
    end
  end

endmodule

// File: rtl/pn_fire_eval.sv
// Enabling test and arc fan-out for the transition owning the current slot.
module pn_fire_eval #(
  parameter int NP = 4,
  parameter int NT = 5,
  parameter int TW = 3,
  parameter logic [NT*NP-1:0] IN_MAT  = '0,
  parameter logic [NT*NP-1:0] OUT_MAT = '0
) (
  input  logic          active_i,
  input  logic [TW-1:0] tsel_i,
  input  logic [NP-1:0] avail_i,
  output logic [NT-1:0] fire_o,
  output logic [NP-1:0] take_o,
  output logic [NP-1:0] give_o
);

  for (genvar t = 0; t < NT; t++) begin : g_tr
    localparam logic [NP-1:0] IROW = IN_MAT[t*NP +: NP];
    assign fire_o[t] = active_i && (tsel_i == TW'(t)) && (&(avail_i | ~IROW));
  end

  always_comb begin
    take_o = '0;
    give_o = '0;
    for (int t = 0; t < NT; t++) begin
      if (fire_o[t]) begin
        take_o = take_o | IN_MAT[t*NP +: NP];
        give_o = give_o | OUT_MAT[t*NP +: NP];
      end
    end
  end

endmodule

// File: rtl/pn_place.sv
// One place: committed count, pending-incoming accumulator, saturation flag.
module pn_place #(
  parameter int CW = 3,
  parameter int IW = 3,
  parameter logic [CW-1:0] INIT_V = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_i,
  input  logic          take_i,
  input  logic          give_i,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);

  localparam int SUMW = ((CW > IW) ? CW : IW) + 1;
  localparam logic [SUMW-1:0] CAP = {{(SUMW-CW){1'b0}}, {CW{1'b1}}};

  logic [CW-1:0]   cnt_q, cnt_n;
  logic [IW-1:0]   inc_q, inc_n;
  logic            ovf_q, ovf_n;
  logic [SUMW-1:0] sum;
  logic            en;

  always_comb begin
    sum   = SUMW'(cnt_q) + SUMW'(inc_q);
    cnt_n = cnt_q;
    inc_n = inc_q;
    ovf_n = ovf_q;
    if (commit_i) begin
      if (sum > CAP) begin
        cnt_n = '1;
        ovf_n = 1'b1;
      end else begin
        cnt_n = sum[CW-1:0];
      end
      inc_n = '0;
    end else begin
      if (take_i) cnt_n = cnt_q - 1'b1;
      if (give_i) inc_n = inc_q + 1'b1;
    end
  end

  assign en = commit_i | take_i | give_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT_V;
      inc_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_n;
      inc_q <= inc_n;
      ovf_q <= ovf_n;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

endmodule

// File: rtl/pn_engine.sv
// Time-slotted marked Petri net engine (top).
module pn_engine
  import pn_pkg::*;
#(
  parameter int NP = 4,
  parameter int NT = 5,
  parameter int CW = 3,
  parameter logic [NT*NP-1:0] IN_MAT  = 20'h10C21,
  parameter logic [NT*NP-1:0] OUT_MAT = 20'h481C2,
  parameter logic [NP*CW-1:0] INIT    = 12'h002,
  parameter int LW = 16,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  output logic [NP*CW-1:0] marking,
  output logic [NT-1:0] fire,
  output logic          boundary,
  output logic          overflow
);

  localparam int TW = pn_bits(NT);
  localparam int IW = pn_bits(NT + 1);

  logic          commit, active;
  logic [TW-1:0] tsel;
  logic [NP-1:0] avail, take, give, ovf;
  logic [NT-1:0] fire_now;
  logic [CW-1:0] cnt [NP];

  logic [NT-1:0] fire_q, fire_n;
  logic          bnd_q, bnd_n;

  pn_slot_seq #(
    .NT(NT), .TW(TW), .LW(LW), .SEED(SEED)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .order_i(pn_order_e'(mode)),
    .commit_o(commit), .active_o(active), .tsel_o(tsel)
  );

  pn_fire_eval #(
    .NP(NP), .NT(NT), .TW(TW), .IN_MAT(IN_MAT), .OUT_MAT(OUT_MAT)
  ) u_eval (
    .active_i(active), .tsel_i(tsel), .avail_i(avail),
    .fire_o(fire_now), .take_o(take), .give_o(give)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pl
    pn_place #(
      .CW(CW), .IW(IW), .INIT_V(INIT[p*CW +: CW])
    ) u_place (
      .clk(clk), .rst_n(rst_n), .commit_i(commit),
      .take_i(take[p]), .give_i(give[p]),
      .count_o(cnt[p]), .ovf_o(ovf[p])
    );
    assign avail[p] = |cnt[p];
    assign marking[p*CW +: CW] = cnt[p];
  end

  always_comb begin
    fire_n = fire_now;
    bnd_n  = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= '0;
      bnd_q  <= 1'b0;
    end else begin
      fire_q <= fire_n;
      bnd_q  <= bnd_n;
    end
  end

  assign fire     = fire_q;
  assign boundary = bnd_q;
  assign overflow = |ovf;

endmodule

// File: rtl/pn_engine_chk.sv
// Port-level checker for pn_engine.
module pn_engine_chk #(
  parameter int NP = 4,
  parameter int NT = 5,
  parameter int CW = 3,
  parameter logic [NT*NP-1:0] IN_MAT = '0,
  parameter logic [NP*CW-1:0] INIT   = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode,
  input logic [NP*CW-1:0] marking,
  input logic [NT-1:0]    fire,
  input logic             boundary,
  input logic             overflow
);

  localparam int GW = $clog2(NT + 2) + 1;
  localparam logic [GW-1:0] PERIOD = GW'(NT + 1);

  logic [GW-1:0] gap_q;
  logic          seen_q, live_q, mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      live_q <= 1'b1;
      mode_d <= 1'b0;
    end else begin
      mode_d <= mode;
      if (boundary) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
        live_q <= (mode_d == 1'b0);
      end else if (gap_q < PERIOD) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (marking == INIT && fire == '0 && !boundary && !overflow));

  // R2
  a_r2_period: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && boundary) |-> (gap_q == PERIOD));

  a_r2_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !boundary) |-> (gap_q < PERIOD));

  // R3
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  for (genvar t = 0; t < NT; t++) begin : g_t
    // R4
    a_r4_fixed_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && live_q && fire[t]) |-> (gap_q == GW'(t + 1)));

    for (genvar p = 0; p < NP; p++) begin : g_p
      if (IN_MAT[t*NP + p]) begin : g_arc
        // R6
        a_r6_take: assert property (@(posedge clk) disable iff (!rst_n)
          fire[t] |-> (marking[p*CW +: CW] < $past(marking[p*CW +: CW])));
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_pm
    // R7
    a_r7_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |-> (marking[p*CW +: CW] <= $past(marking[p*CW +: CW])));
  end

endmodule

bind pn_engine pn_engine_chk #(
  .NP(NP), .NT(NT), .CW(CW), .IN_MAT(IN_MAT), .INIT(INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .marking(marking),
  .fire(fire), .boundary(boundary), .overflow(overflow)
);

// File: tb/sim_pn_engine.sv
module sim_pn_engine;

  // Net under test (R10 layout: arc bit t*NP+p, place p at marking[p*CW +: CW]):
  // T0: P0->P1, T1: P1->P2+P3, T2: P2+P3->P0, T3: source->P3, T4: P0->P2
  localparam int NP = 4;
  localparam int NT = 5;
  localparam int CW = 3;
  localparam logic [NT*NP-1:0] IN_MAT  = 20'h10C21;
  localparam logic [NT*NP-1:0] OUT_MAT = 20'h481C2;
  localparam logic [NP*CW-1:0] INIT    = 12'h002;
  localparam int MAXC = (1 << CW) - 1;
  localparam int SRC  = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             mode;
  logic [NP*CW-1:0] marking;
  logic [NT-1:0]    fire;
  logic             boundary;
  logic             overflow;

  pn_engine #(
    .NP(NP), .NT(NT), .CW(CW), .IN_MAT(IN_MAT), .OUT_MAT(OUT_MAT), .INIT(INIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .marking(marking),
    .fire(fire), .boundary(boundary), .overflow(overflow)
  );

  int checks = 0;
  int failures = 0;
  int mc [NP];
  int mi [NP];
  bit movf;
  bit next_mode, cur_mode;
  int pos_set;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int mk(input int p);
    return int'(marking[p*CW +: CW]);
  endfunction

  function automatic bit t_enabled(input int t);
    for (int p = 0; p < NP; p++)
      if (IN_MAT[t*NP + p] && mc[p] == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_fire(input int t);
    for (int p = 0; p < NP; p++) begin
      if (IN_MAT[t*NP + p]) mc[p]--;
      if (OUT_MAT[t*NP + p]) mi[p]++;
    end
  endtask

  task automatic model_commit();
    for (int p = 0; p < NP; p++) begin
      if (mc[p] + mi[p] > MAXC) begin
        mc[p] = MAXC;
        movf = 1'b1;
      end else begin
        mc[p] = mc[p] + mi[p];
      end
      mi[p] = 0;
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      mc[p] = int'(INIT[p*CW +: CW]);
      mi[p] = 0;
    end
    movf = 1'b0;
  endtask

  task automatic check_marking(input string tag);
    for (int p = 0; p < NP; p++)
      chk(mk(p) == mc[p], tag, $sformatf("place %0d count", p), mk(p), mc[p]);
  endtask

  task automatic check_reset_state();
    chk(marking == INIT, "R1", "marking in reset", int'(marking), int'(INIT));
    chk(fire == '0, "R1", "fire in reset", int'(fire), 0);
    chk(!boundary, "R1", "boundary in reset", int'(boundary), 0);
    chk(!overflow, "R1", "overflow in reset", int'(overflow), 0);
    chk(marking[CW-1:0] == 3'd2, "R10", "place 0 field", int'(marking[CW-1:0]), 2);
  endtask

  // One major cycle: boundary cycle, then NT strobe cycles.
  task automatic run_major(input bit strict, input bit nm);
    int n;
    logic [NT-1:0] fired;
    int t;
    if (strict) begin
      @(negedge clk);
      chk(boundary, "R2", "boundary after NT+1 cycles", int'(boundary), 1);
    end else begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!boundary && n < NT + 3);
      chk(boundary, "R1", "first boundary after reset", int'(boundary), 1);
    end
    model_commit();
    check_marking("R7");
    chk(overflow == movf, "R8", "overflow flag", int'(overflow), int'(movf));
    cur_mode = next_mode;
    fired = '0;
    for (int j = 0; j < NT; j++) begin
      @(negedge clk);
      chk(!boundary, "R2", "boundary inside major cycle", int'(boundary), 0);
      if (!cur_mode) begin
        if (t_enabled(j)) begin
          chk(fire == NT'(1 << j), "R4", $sformatf("fixed slot %0d strobe", j),
              int'(fire), 1 << j);
          model_fire(j);
        end else begin
          chk(fire == '0, "R5", $sformatf("disabled T%0d no strobe", j), int'(fire), 0);
        end
      end else begin
        chk($countones(fire) <= 1, "R3", "single strobe", $countones(fire), 1);
        if (fire != '0) begin
          t = 0;
          for (int i = 0; i < NT; i++) if (fire[i]) t = i;
          chk(!fired[t], "R3", $sformatf("T%0d once per major", t), 1, 0);
          chk(t_enabled(t), "R5", $sformatf("T%0d enabled when fired", t), 0, 1);
          model_fire(t);
          fired[t] = 1'b1;
          if (t == SRC) pos_set |= (1 << j);
        end
      end
      check_marking("R6");
    end
    if (cur_mode)
      chk(fired[SRC], "R9", "source transition got a slot", int'(fired[SRC]), 1);
    next_mode = nm;
    mode = nm;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    pos_set = 0;
    mode = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    model_reset();
    next_mode = 1'b0;
    rst_n = 1'b1;
    run_major(1'b0, 1'b0);
    // fixed order, then shuffled, then random mix of modes
    for (int i = 0; i < 160; i++) begin
      bit nm;
      if (i < 39)       nm = 1'b0;
      else if (i < 99)  nm = 1'b1;
      else              nm = 1'($urandom_range(0, 1));
      run_major(1'b1, nm);
    end
    chk($countones(pos_set) >= 2, "R9", "source slot positions seen",
        $countones(pos_set), 2);
    chk(overflow, "R8", "saturation reached", int'(overflow), 1);

    // mid-run reset restores initial marking and clears overflow
    rst_n = 1'b0;
    mode = 1'b0;
    @(negedge clk);
    check_reset_state();
    model_reset();
    next_mode = 1'b0;
    rst_n = 1'b1;
    run_major(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) run_major(1'b1, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule